// File: doc/BRIEF.md
# Adapter Configuration Loader

After reset this block collects the adapter's stored configuration from a serial EEPROM. It does not drive the EEPROM wires. It asks a separate byte reader for one byte at a time, using a start pulse and an address, and waits for a done strobe that carries the data. The block decodes the fields it needs from these bytes and holds the results in output registers for the rest of the adapter.

Before it issues any read, the loader raises a request to the board glue logic and waits for that logic to acknowledge it. The reads then follow a fixed order:

- the line-rate byte;
- the buffer-RAM size byte;
- the six station-address bytes, taken from consecutive EEPROM locations.

A nonzero line-rate byte selects the slow 4 Mbps ring rate. A zero byte selects 16 Mbps. The RAM byte counts 128 KB units and is reported in kilobytes. Once all eight bytes are in, a valid flag rises and stays high until the next reset. No further reads are issued after that.

States of the sequencer, with their transitions:

| State | Meaning | Transitions |
|-------|---------|-------------|
| ST_GLUE | Holds the glue request. | Goes to ST_ISSUE when `glue_ack` is sampled high. |
| ST_ISSUE | Pulses `rd_start` with the current address for one cycle. | Always goes to ST_WAIT. |
| ST_WAIT | Waits for `rd_done`. | Goes back to ST_ISSUE for the next field when `rd_done` arrives. Goes to ST_DONE when the eighth byte arrives. |
| ST_DONE | Terminal state: `cfg_valid` is high. | Stays until the next reset. |

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `glue_req` is 1. In that state `rd_start`, `cfg_valid`, `rate_sel`, `ram_kb` and `station_addr` are all 0.
- R2: `glue_req` stays 1 until `glue_ack` is sampled high on a rising edge, and it is 0 from the following cycle onward. No `rd_start` occurs before that acknowledge.
- R3: The first `rd_start` occurs in the cycle right after the acknowledge edge, with `rd_addr` equal to `SPEED_OFS`.
- R4: Reads follow this order, and no other:
  - `SPEED_OFS`;
  - `RAM_OFS`;
  - `MAC_OFS+0` up to `MAC_OFS+5`.

  Each `rd_start` lasts exactly one cycle. The next `rd_start` comes in the cycle after the edge that samples `rd_done`. At most eight reads occur after each reset.
- R5: `rd_done` has no effect unless a read is pending, that is, after a `rd_start` and before its `rd_done`. Its effect does not depend on the cycle of `rd_start` itself, on the glue phase, or on anything after completion.
- R6: `rate_sel` (bit 0 of the speed selection) is 1 when the line-rate byte is nonzero (4 Mbps), and 0 when it is zero (16 Mbps).
- R7: `ram_kb` equals the RAM-size byte times 128, as a 16-bit value.
- R8: Station-address byte i (read from `MAC_OFS+i`) is stored in `station_addr[47-8i:40-8i]`, so byte 0 is in the most significant position. A byte of 0xFF is stored unchanged, with no retry.
- R9: `cfg_valid` becomes 1 in the cycle after the edge that samples the eighth `rd_done`. After that it stays 1, no `rd_start` is issued, and `rate_sel`, `ram_kb` and `station_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glue_req | output | 1 | Request to enable the board glue logic |
| glue_ack | input | 1 | Glue logic acknowledge |
| rd_start | output | 1 | One-cycle request for a byte read |
| rd_addr | output | ADDR_W | EEPROM byte address of the request |
| rd_done | input | 1 | Byte reader completion strobe |
| rd_data | input | 8 | Byte returned, valid with `rd_done` |
| rate_sel | output | 1 | 1 = 4 Mbps, 0 = 16 Mbps |
| ram_kb | output | 16 | On-board RAM size in kilobytes |
| station_addr | output | 48 | Six-byte station address, byte 0 in the top bits |
| cfg_valid | output | 1 | All configuration fields loaded |

## Verification
The assertions watch every cycle for the following:
- a read request issued before the glue handshake;
- a glue request that outlives its acknowledge;
- a start strobe longer than one cycle;
- more than eight requests after reset;
- any output change or new request once the valid flag is up.

Only the bench scenarios can show the rest: that addresses arrive in the prescribed order, that the decoded rate, RAM size and station-address byte positions match the bytes served, and that stray done strobes are ignored. The bench shows this by sweeping every RAM-size byte value against several rate bytes, several read latencies and several glue delays.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int STATION_BYTES = 6;
    localparam int READ_COUNT    = 2 + STATION_BYTES;
    localparam int IDX_W         = $clog2(READ_COUNT);
    localparam int RAM_KB_W      = 16;
    localparam int RAM_SHIFT     = 7;  // 128 KB per unit
    localparam int STATION_W     = 8 * STATION_BYTES;

    typedef enum logic [1:0] {
        ST_GLUE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } cfgld_state_e;
endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SPEED_OFS = 8'h03,
    parameter logic [ADDR_W-1:0] RAM_OFS   = 8'h04,
    parameter logic [ADDR_W-1:0] MAC_OFS   = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glue_ack,
    input  logic              rd_done,
    output logic              glue_req,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              all_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(READ_COUNT - 1);

    cfgld_state_e     state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_GLUE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_GLUE:  if (glue_ack) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (rd_done) begin
                    if (idx == LAST_IDX) begin
                        state_nx = ST_DONE;
                    end else begin
                        idx_nx   = idx + 1'b1;
                        state_nx = ST_ISSUE;
                    end
                end
            end
            ST_DONE:  state_nx = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        glue_req = 1'b0;
        rd_start = 1'b0;
        cap_en   = 1'b0;
        all_done = 1'b0;
        unique case (state)
            ST_GLUE:  glue_req = 1'b1;
            ST_ISSUE: rd_start = 1'b1;
            ST_WAIT:  cap_en   = rd_done;
            ST_DONE:  all_done = 1'b1;
        endcase
        cap_idx = idx;
        if (idx == '0)
            rd_addr = SPEED_OFS;
        else if (idx == IDX_W'(1))
            rd_addr = RAM_OFS;
        else
            rd_addr = MAC_OFS + ADDR_W'(idx) - ADDR_W'(2);
    end
endmodule

// File: rtl/cfgld_fields.sv
module cfgld_fields
    import cfgld_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [IDX_W-1:0]     cap_idx,
    input  logic [7:0]           cap_data,
    output logic                 rate_sel,
    output logic [RAM_KB_W-1:0]  ram_kb,
    output logic [STATION_W-1:0] station_addr
);
    logic       rate_q;
    logic [7:0] ram_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
            ram_q  <= '0;
        end else if (cap_en) begin
            if (cap_idx == '0)        rate_q <= |cap_data;
            if (cap_idx == IDX_W'(1)) ram_q  <= cap_data;
        end
    end

    assign rate_sel = rate_q;
    assign ram_kb   = RAM_KB_W'({ram_q, {RAM_SHIFT{1'b0}}});

    for (genvar g = 0; g < STATION_BYTES; g++) begin : g_sta
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (cap_en && cap_idx == IDX_W'(g + 2))
                byte_q <= cap_data;
        end
        assign station_addr[STATION_W-1-8*g -: 8] = byte_q;
    end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SPEED_OFS = 8'h03,
    parameter logic [ADDR_W-1:0] RAM_OFS   = 8'h04,
    parameter logic [ADDR_W-1:0] MAC_OFS   = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              glue_req,
    input  logic              glue_ack,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_done,
    input  logic [7:0]        rd_data,
    output logic              rate_sel,
    output logic [15:0]       ram_kb,
    output logic [47:0]       station_addr,
    output logic              cfg_valid
);
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;

    cfgld_seq #(
        .ADDR_W   (ADDR_W),
        .SPEED_OFS(SPEED_OFS),
        .RAM_OFS  (RAM_OFS),
        .MAC_OFS  (MAC_OFS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .glue_ack (glue_ack),
        .rd_done  (rd_done),
        .glue_req (glue_req),
        .rd_start (rd_start),
        .rd_addr  (rd_addr),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .all_done (cfg_valid)
    );

    cfgld_fields u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en       (cap_en),
        .cap_idx      (cap_idx),
        .cap_data     (rd_data),
        .rate_sel     (rate_sel),
        .ram_kb       (ram_kb),
        .station_addr (station_addr)
    );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        glue_req,
    input logic        glue_ack,
    input logic        rd_start,
    input logic        cfg_valid,
    input logic        rate_sel,
    input logic [15:0] ram_kb,
    input logic [47:0] station_addr
);
    logic       glue_seen;
    logic [3:0] starts;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glue_seen <= 1'b0;
            starts    <= '0;
        end else begin
            if (glue_req && glue_ack) glue_seen <= 1'b1;
            if (rd_start && starts != 4'hF) starts <= starts + 1'b1;
        end
    end

    // R2: no read before the glue handshake has completed
    p_read_after_glue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> glue_seen);

    // R2: request drops right after it is acknowledged
    p_glue_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (glue_req && glue_ack) |=> !glue_req);

    // R4: start strobe is a single cycle
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    // R4: at most eight reads per reset
    p_read_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (starts < 4'd8));

    // R9: valid is sticky and the fields are frozen
    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && $stable(rate_sel) && $stable(ram_kb)
                       && $stable(station_addr)));

    // R9: no bus activity once loaded
    p_quiet_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (!rd_start && !glue_req));
endmodule

bind eeprom_cfg_loader cfgld_checker u_cfgld_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .glue_req     (glue_req),
    .glue_ack     (glue_ack),
    .rd_start     (rd_start),
    .cfg_valid    (cfg_valid),
    .rate_sel     (rate_sel),
    .ram_kb       (ram_kb),
    .station_addr (station_addr)
);

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;
    localparam logic [7:0] SP_OFS = 8'h03;
    localparam logic [7:0] RM_OFS = 8'h04;
    localparam logic [7:0] MB_OFS = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glue_ack = 1'b0;
    logic        rd_done = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        glue_req, rd_start, rate_sel, cfg_valid;
    logic [7:0]  rd_addr;
    logic [15:0] ram_kb;
    logic [47:0] station_addr;

    always #2 clk = ~clk;  // 250 MHz

    eeprom_cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .glue_req(glue_req), .glue_ack(glue_ack),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_done(rd_done),
        .rd_data(rd_data), .rate_sel(rate_sel), .ram_kb(ram_kb),
        .station_addr(station_addr), .cfg_valid(cfg_valid)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] speed_byte(int k);
        case (k % 4)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h80;
            default: return 8'hFF;
        endcase
    endfunction

    // served byte for read index i (0 speed, 1 RAM, 2..7 station bytes)
    function automatic logic [7:0] served(int k, int i);
        if (i == 0) return speed_byte(k);
        if (i == 1) return k[7:0];
        if (i == 7 && (k % 5) == 0) return 8'hFF;
        return 8'((k * 37 + i * 53) & 255);
    endfunction

    function automatic logic [7:0] exp_addr(int i);
        if (i == 0) return SP_OFS;
        if (i == 1) return RM_OFS;
        return MB_OFS + 8'(i - 2);
    endfunction

    task automatic one_run(input int k);
        int          lat;
        int          gwait;
        logic [47:0] exp_sta;
        lat   = 1 + (k % 3);
        gwait = k % 4;
        rst_n = 1'b0; glue_ack = 1'b0; rd_done = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1", "glue_req", 64'(glue_req), 64'd1);
        check("R1", "rd_start", 64'(rd_start), 64'd0);
        check("R1", "cfg_valid", 64'(cfg_valid), 64'd0);
        check("R1", "rate_sel", 64'(rate_sel), 64'd0);
        check("R1", "ram_kb", 64'(ram_kb), 64'd0);
        check("R1", "station_addr", 64'(station_addr), 64'd0);
        rst_n = 1'b1;
        // glue phase, with stray done strobes (R5)
        rd_done = 1'b1; rd_data = 8'hA5;
        for (int w = 0; w < gwait; w++) begin
            @(negedge clk);
            check("R2", "glue_req held", 64'(glue_req), 64'd1);
            check("R2", "no early read", 64'(rd_start), 64'd0);
        end
        rd_done = 1'b0;
        @(negedge clk);
        glue_ack = 1'b1;
        @(negedge clk);
        glue_ack = 1'b0;
        check("R2", "glue_req dropped", 64'(glue_req), 64'd0);
        check("R3", "first start", 64'(rd_start), 64'd1);
        for (int i = 0; i < 8; i++) begin
            check("R4", "start present", 64'(rd_start), 64'd1);
            check("R4", "address order", 64'(rd_addr), 64'(exp_addr(i)));
            if (k % 2 == 1) begin
                rd_done = 1'b1; rd_data = 8'hC3;  // R5 stray in issue cycle
            end
            for (int c = 0; c < lat; c++) begin
                @(negedge clk);
                rd_done = 1'b0;
                check("R4", "start single cycle", 64'(rd_start), 64'd0);
            end
            rd_done = 1'b1; rd_data = served(k, i);
            @(negedge clk);
            rd_done = 1'b0; rd_data = 8'h00;
        end
        exp_sta = '0;
        for (int i = 0; i < 6; i++) exp_sta[47-8*i -: 8] = served(k, i + 2);
        check("R9", "valid raised", 64'(cfg_valid), 64'd1);
        check("R9", "no more reads", 64'(rd_start), 64'd0);
        check("R6", "rate_sel", 64'(rate_sel), 64'(speed_byte(k) != 8'h00));
        check("R7", "ram_kb", 64'(ram_kb), 64'(k) * 64'd128);
        check("R8", "station_addr", 64'(station_addr), 64'(exp_sta));
        // R5/R9: strobes after completion change nothing
        rd_done = 1'b1; rd_data = 8'h5A;
        repeat (2) @(negedge clk);
        rd_done = 1'b0;
        @(negedge clk);
        check("R5", "ram_kb after stray", 64'(ram_kb), 64'(k) * 64'd128);
        check("R5", "station after stray", 64'(station_addr), 64'(exp_sta));
        check("R9", "valid held", 64'(cfg_valid), 64'd1);
        check("R9", "still quiet", 64'(rd_start), 64'd0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) one_run(k);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule